// File: doc/BRIEF.md
# Three-Way Bus Grant Requester

This block is the front end a DMA engine uses to win a shared bus arbitrated with three signals: request, grant and grant-acknowledge. When the DMA sequencer raises its need for the bus, the block drives an active-low request and waits for the arbiter's grant. A grant alone is not taken as permission to use the bus. The block first watches the previous master's acknowledge, the address strobe, every data-size acknowledge line and, in asynchronous bus mode, the termination line. Only when all of them read released does it drive grant-acknowledge and tell the sequencer it owns the bus.

Once it owns the bus it cannot be preempted. The arbiter withdrawing grant has no effect, and mastership ends only when the sequencer reports that its last transfer is complete. One extra holding cycle follows before grant-acknowledge is released. Every bus-side input passes through a multi-stage synchronizer before the controller looks at it. If the sequencer drops its need before ownership is reached, the request is withdrawn. This happens, for example, when the target memory region changes. The request is raised again when the need returns.

Top module: `bus_gnt_req`

## Requirements
- R1: After reset, req_n and gack_out_n are 1 and bus_owned is 0.
- R2: When dma_need is 1 in idle, req_n goes to 0 after the next clock edge. If dma_need falls before ownership, req_n returns to 1 after the next edge.
- R3: Ownership is never taken on a synchronized grant (gnt_n=0) alone. While any checked release line reads 0, gack_out_n stays 1.
- R4: The checked release lines are gack_in_n, astb_in_n and every bit of szack_in_n. term_in_n is checked only when async_mode is 1, and it is ignored when async_mode is 0.
- R5: Bus inputs pass through SYNC_STAGES flip-flops (default 2). With grant already seen, gack_out_n falls three clock edges after the last release line rises.
- R6: On the edge that ownership is taken, gack_out_n goes to 0, req_n goes to 1 and bus_owned goes to 1 together.
- R7: While the block owns the bus, neither deasserting gnt_n nor dropping dma_need ends ownership.
- R8: A dma_done pulse during ownership clears bus_owned after the next edge. gack_out_n stays 0 for that one holding cycle and goes to 1 one edge later.
- R9: If the grant is withdrawn while the block is waiting for release, it goes back to requesting. It keeps req_n at 0 and needs a new grant before it can take ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_need | input | 1 | DMA sequencer wants the bus (same clock domain) |
| dma_done | input | 1 | One-cycle pulse: last transfer cycle finished |
| async_mode | input | 1 | 1 = asynchronous bus, termination line is checked |
| gnt_n | input | 1 | Arbiter grant, active low |
| gack_in_n | input | 1 | Grant-acknowledge from the previous master, active low |
| astb_in_n | input | 1 | Address strobe on the bus, active low |
| szack_in_n | input | SZACK_W | Data-size acknowledge lines from the slave, active low |
| term_in_n | input | 1 | Synchronous termination from the slave, active low |
| req_n | output | 1 | Bus request, active low |
| gack_out_n | output | 1 | Grant-acknowledge driven by this block, active low |
| bus_owned | output | 1 | Tells the sequencer it may run transfer cycles |

## Verification
The assertions assume that dma_done pulses only while the block owns the bus. They also assume that async_mode and dma_need come from the block's own clock domain, so neither needs synchronizing. The stimulus changes every input only at falling clock edges. It holds each bus line steady long enough for the synchronizer to pass it through. It raises dma_done for exactly one cycle, and only after ownership has been seen, and it drops dma_need together with that pulse. Grant and release lines move one at a time, so each expected edge count follows from a single change.

// File: rtl/bus_gnt_req_pkg.sv
package bus_gnt_req_pkg;
   typedef enum logic [2:0] {
      GR_IDLE = 3'd0,
      GR_REQ  = 3'd1,
      GR_WREL = 3'd2,
      GR_OWN  = 3'd3,
      GR_HOLD = 3'd4
   } gr_state_t;
endpackage

// File: rtl/bus_gnt_sync.sv
module bus_gnt_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $error("bus_gnt_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         initial $error("bus_gnt_sync: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '1;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bus_gnt_release.sv
module bus_gnt_release #(
   parameter int SZACK_W  = 2,
   parameter bit HAS_TERM = 1'b1
) (
   input  logic               gack_s_n,
   input  logic               astb_s_n,
   input  logic [SZACK_W-1:0] szack_s_n,
   input  logic               term_s_n,
   input  logic               async_mode,
   output logic               rel_ok
);
   logic base_free;
   logic term_free;

   assign base_free = gack_s_n & astb_s_n & (&szack_s_n);

   generate
      if (HAS_TERM) begin : g_term
         assign term_free = term_s_n | ~async_mode;
      end else begin : g_noterm
         logic unused_term;
         assign unused_term = term_s_n ^ async_mode;
         assign term_free   = 1'b1;
      end
   endgenerate

   assign rel_ok = base_free & term_free;
endmodule

// File: rtl/bus_gnt_fsm.sv
module bus_gnt_fsm
   import bus_gnt_req_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dma_need,
   input  logic dma_done,
   input  logic gnt_s,
   input  logic rel_ok,
   output logic req_n,
   output logic gack_out_n,
   output logic bus_owned
);
   gr_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GR_IDLE: if (dma_need) state_d = GR_REQ;
         GR_REQ: begin
            if (!dma_need)  state_d = GR_IDLE;
            else if (gnt_s) state_d = GR_WREL;
         end
         GR_WREL: begin
            if (!dma_need)   state_d = GR_IDLE;
            else if (!gnt_s) state_d = GR_REQ;
            else if (rel_ok) state_d = GR_OWN;
         end
         GR_OWN:  if (dma_done) state_d = GR_HOLD;
         GR_HOLD: state_d = GR_IDLE;
         default: state_d = GR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GR_IDLE;
      else        state_q <= state_d;
   end

   assign req_n      = ~((state_q == GR_REQ) || (state_q == GR_WREL));
   assign gack_out_n = ~((state_q == GR_OWN) || (state_q == GR_HOLD));
   assign bus_owned  = (state_q == GR_OWN);

   AST_ACK_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gack_out_n) |-> ($past(rel_ok) && $past(gnt_s))); // R3
   AST_REQ_OFF_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      !gack_out_n |-> req_n); // R6
   AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_owned && !dma_done) |=> bus_owned); // R7
   AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_owned) |-> !gack_out_n); // R8
   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_owned) |=> gack_out_n); // R8
endmodule

// File: rtl/bus_gnt_req.sv
module bus_gnt_req #(
   parameter int SZACK_W     = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_TERM    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dma_need,
   input  logic               dma_done,
   input  logic               async_mode,
   input  logic               gnt_n,
   input  logic               gack_in_n,
   input  logic               astb_in_n,
   input  logic [SZACK_W-1:0] szack_in_n,
   input  logic               term_in_n,
   output logic               req_n,
   output logic               gack_out_n,
   output logic               bus_owned
);
   localparam int SW = SZACK_W + 4;

   logic [SW-1:0] raw_v, syn_v;
   logic          rel_ok;

   generate
      if (SZACK_W < 1) begin : g_bad_szack
         initial $error("bus_gnt_req: SZACK_W must be at least 1");
      end
   endgenerate

   assign raw_v = {gnt_n, gack_in_n, astb_in_n, term_in_n, szack_in_n};

   bus_gnt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (syn_v)
   );

   bus_gnt_release #(.SZACK_W(SZACK_W), .HAS_TERM(HAS_TERM)) u_rel (
      .gack_s_n   (syn_v[SW-2]),
      .astb_s_n   (syn_v[SW-3]),
      .szack_s_n  (syn_v[SZACK_W-1:0]),
      .term_s_n   (syn_v[SZACK_W]),
      .async_mode (async_mode),
      .rel_ok     (rel_ok)
   );

   bus_gnt_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .dma_need   (dma_need),
      .dma_done   (dma_done),
      .gnt_s      (~syn_v[SW-1]),
      .rel_ok     (rel_ok),
      .req_n      (req_n),
      .gack_out_n (gack_out_n),
      .bus_owned  (bus_owned)
   );
endmodule

// File: tb/tb_bus_gnt_req.sv
module tb_bus_gnt_req;
   localparam int SZW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_need = 1'b0, dma_done = 1'b0, async_mode = 1'b0;
   logic gnt_n = 1'b1, gack_in_n = 1'b1, astb_in_n = 1'b1, term_in_n = 1'b1;
   logic [SZW-1:0] szack_in_n = '1;
   logic req_n, gack_out_n, bus_owned;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   typedef struct {
      int    at;
      logic  br;
      logic  ack;
      logic  own;
      string tag;
   } exp_t;
   exp_t exq[$];

   bus_gnt_req #(.SZACK_W(SZW)) dut (
      .clk(clk), .rst_n(rst_n), .dma_need(dma_need), .dma_done(dma_done),
      .async_mode(async_mode), .gnt_n(gnt_n), .gack_in_n(gack_in_n),
      .astb_in_n(astb_in_n), .szack_in_n(szack_in_n), .term_in_n(term_in_n),
      .req_n(req_n), .gack_out_n(gack_out_n), .bus_owned(bus_owned)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic tick(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic chk_at(int off, logic br, logic ack, logic own, string tag);
      exp_t e;
      e.at = cyc + off; e.br = br; e.ack = ack; e.own = own; e.tag = tag;
      exq.push_back(e);
   endtask

   // monitor: pops expected items at their cycle and compares
   always @(negedge clk) begin
      while (exq.size() > 0 && exq[0].at <= cyc) begin
         exp_t e;
         e = exq.pop_front();
         checks++;
         if (e.at < cyc || req_n !== e.br || gack_out_n !== e.ack || bus_owned !== e.own) begin
            failures++;
            $display("FAIL %s cyc=%0d actual req_n=%b gack_out_n=%b bus_owned=%b expected %b %b %b",
                     e.tag, cyc, req_n, gack_out_n, bus_owned, e.br, e.ack, e.own);
         end
      end
   end

   task automatic set_line(int which, logic v);
      case (which)
         0: gack_in_n = v;
         1: astb_in_n = v;
         2: szack_in_n[0] = v;
         3: szack_in_n[1] = v;
         default: term_in_n = v;
      endcase
   endtask

   task automatic finish_own(string tag);
      gnt_n = 1'b1; dma_need = 1'b0; dma_done = 1'b1;
      chk_at(1, 1'b1, 1'b0, 1'b0, tag);
      chk_at(2, 1'b1, 1'b1, 1'b0, tag);
      tick(1);
      dma_done = 1'b0;
      tick(4);
   endtask

   // R3 R4 R5: one release line held busy, then freed
   task automatic release_case(int which, string tag);
      set_line(which, 1'b0);
      dma_need = 1'b1; gnt_n = 1'b0;
      chk_at(4, 1'b0, 1'b1, 1'b0, {tag, " R3"});
      chk_at(6, 1'b0, 1'b1, 1'b0, {tag, " R3"});
      tick(6);
      set_line(which, 1'b1);
      chk_at(2, 1'b0, 1'b1, 1'b0, {tag, " R5"});
      chk_at(3, 1'b1, 1'b0, 1'b1, {tag, " R5"});
      tick(4);
      finish_own({tag, " R8"});
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      chk_at(1, 1'b1, 1'b1, 1'b0, "R1 reset");
      tick(2);

      // main flow R2 R6 R7 R8
      dma_need = 1'b1;
      chk_at(1, 1'b0, 1'b1, 1'b0, "R2 request");
      tick(2);
      gnt_n = 1'b0;
      chk_at(3, 1'b0, 1'b1, 1'b0, "R3 wait cycle");
      chk_at(4, 1'b1, 1'b0, 1'b1, "R6 take");
      tick(6);
      gnt_n = 1'b1; dma_need = 1'b0;
      chk_at(5, 1'b1, 1'b0, 1'b1, "R7 no preempt");
      tick(6);
      dma_done = 1'b1;
      chk_at(1, 1'b1, 1'b0, 1'b0, "R8 hold");
      chk_at(2, 1'b1, 1'b1, 1'b0, "R8 release");
      tick(1);
      dma_done = 1'b0;
      tick(4);

      // each release line R3 R4 R5
      async_mode = 1'b1;
      release_case(0, "R4 gack");
      release_case(1, "R4 astb");
      release_case(2, "R4 szack0");
      release_case(3, "R4 szack1");
      release_case(4, "R4 term async");

      // term ignored in synchronous mode R4
      async_mode = 1'b0;
      term_in_n = 1'b0;
      dma_need = 1'b1; gnt_n = 1'b0;
      chk_at(4, 1'b1, 1'b0, 1'b1, "R4 term ignored");
      tick(5);
      finish_own("R8 after sync mode");
      term_in_n = 1'b1;
      tick(3);

      // request dropped before grant R2
      dma_need = 1'b1;
      chk_at(1, 1'b0, 1'b1, 1'b0, "R2 reissue");
      tick(2);
      dma_need = 1'b0;
      chk_at(1, 1'b1, 1'b1, 1'b0, "R2 drop");
      tick(3);

      // request dropped while waiting for release R2
      gack_in_n = 1'b0;
      dma_need = 1'b1; gnt_n = 1'b0;
      tick(5);
      dma_need = 1'b0;
      chk_at(1, 1'b1, 1'b1, 1'b0, "R2 drop in wait");
      tick(2);
      gnt_n = 1'b1; gack_in_n = 1'b1;
      tick(4);

      // grant withdrawn before acknowledge R9
      gack_in_n = 1'b0;
      dma_need = 1'b1; gnt_n = 1'b0;
      tick(5);
      gnt_n = 1'b1;
      tick(4);
      gack_in_n = 1'b1;
      chk_at(3, 1'b0, 1'b1, 1'b0, "R9 no take");
      chk_at(5, 1'b0, 1'b1, 1'b0, "R9 still requesting");
      tick(6);
      gnt_n = 1'b0;
      chk_at(4, 1'b1, 1'b0, 1'b1, "R9 regrant");
      tick(5);
      finish_own("R8 after regrant");

      tick(2);
      if (exq.size() != 0) begin
         failures++;
         $display("FAIL pending expected items actual=%0d expected=0", exq.size());
      end
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule